// File: doc/BRIEF.md
# Secured Configuration Readback Controller

This controller sits behind a serial test-port style command path and guards a small nonvolatile store. The store holds a user signature word for design-specific data such as a build date or code revision, a fixed device identifier, and the main configuration image. An 8-bit opcode is presented in parallel with a load strobe. Read data then leaves one bit per shift cycle on a serial output, least significant bit first. Programming data enters the same way on a serial input.

A security bit locks the configuration image. While it is set, a configuration read is refused: the output shifts zeros and a status flag rises. The signature and the identifier stay readable. Only a bulk erase clears the lock, and the erase also returns the image and the signature to their blank state. Programming follows nonvolatile cell rules and can only turn ones into zeros. Every programming command holds a busy flag for a fixed number of cycles, and no command is accepted while that flag is high.

Top module: `scr_ctrl`

## Requirements
- R1: After reset, sdo, busy and blocked are 0. The store is blank: the image and the signature read as all ones, and security is clear.
- R2: Opcode 0x51 loads the SIG_W-bit signature into the output register, zero-extended to CFG_W bits. sdo shows bit 0 in the cycle after the load. Each cycle with shift_en high advances sdo by one bit, and zeros follow the last bit. This read works whether or not security is set.
- R3: Opcode 0x52 returns the DEV_ID parameter in the same way, whether or not security is set.
- R4: Opcode 0x53 with security clear returns the CFG_W-bit configuration image, least significant bit first.
- R5: Opcode 0x53 with security set returns all zeros and sets blocked. blocked holds until the next accepted known opcode, which clears it.
- R6: Each cycle with shift_en high shifts sdi into a CFG_W-bit data register. Of the last CFG_W bits shifted in, the first becomes bit 0. Opcode 0xA1 replaces the image with the bitwise AND of the image and that register.
- R7: Opcode 0xA2 replaces the signature with the bitwise AND of the signature and data register bits SIG_W-1:0.
- R8: Opcode 0xA5 sets security. No opcode other than bulk erase clears it.
- R9: Opcode 0xE7 (bulk erase) sets every image and signature bit to 1 and clears security.
- R10: Opcodes 0xA1, 0xA2, 0xA5 and 0xE7 raise busy for exactly PROG_CYC cycles, starting in the cycle after acceptance. A load while busy is high is ignored.
- R11: Any other opcode is ignored. The output stream, busy, blocked and the store do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_load | input | 1 | Strobe: present op_code this cycle |
| op_code | input | 8 | Command opcode |
| shift_en | input | 1 | Shift the serial data path by one bit |
| sdi | input | 1 | Serial data in, LSB first |
| sdo | output | 1 | Serial data out, LSB first |
| busy | output | 1 | Programming in progress |
| blocked | output | 1 | Last configuration read was refused |

## Verification
The bench builds the block with CFG_W = 48 and PROG_CYC = 5. The default image is 64 bits wide and the default busy time is longer. The 48-bit image is still wider than the 32-bit signature, so zero extension of signature and identifier reads is exercised. Each full programming window ends within a handful of cycles, which lets the bench count the exact busy length and issue a command inside the window to show that it is dropped. With these values the bench also walks through a lock, refused reads, further programming while locked and a bulk erase quickly, and compares against a reference model on every clock.

// File: rtl/scr_pkg.sv
package scr_pkg;

   localparam logic [7:0] OP_RSIG  = 8'h51;
   localparam logic [7:0] OP_RID   = 8'h52;
   localparam logic [7:0] OP_RCFG  = 8'h53;
   localparam logic [7:0] OP_PCFG  = 8'hA1;
   localparam logic [7:0] OP_PSIG  = 8'hA2;
   localparam logic [7:0] OP_LOCK  = 8'hA5;
   localparam logic [7:0] OP_ERASE = 8'hE7;

   typedef enum logic [2:0] {
      K_NONE,
      K_RSIG,
      K_RID,
      K_RCFG,
      K_PCFG,
      K_PSIG,
      K_LOCK,
      K_ERASE
   } cmd_kind_e;

endpackage

// File: rtl/scr_decode.sv
module scr_decode
   import scr_pkg::*;
(
   input  logic [7:0] op_code,
   output cmd_kind_e  kind,
   output logic       is_read,
   output logic       is_prog
);

   always_comb begin
      case (op_code)
         OP_RSIG:  kind = K_RSIG;
         OP_RID:   kind = K_RID;
         OP_RCFG:  kind = K_RCFG;
         OP_PCFG:  kind = K_PCFG;
         OP_PSIG:  kind = K_PSIG;
         OP_LOCK:  kind = K_LOCK;
         OP_ERASE: kind = K_ERASE;
         default:  kind = K_NONE;
      endcase
   end

   assign is_read = (kind == K_RSIG) || (kind == K_RID) || (kind == K_RCFG);
   assign is_prog = (kind == K_PCFG) || (kind == K_PSIG) ||
                    (kind == K_LOCK) || (kind == K_ERASE);

endmodule

// File: rtl/scr_busy.sv
module scr_busy #(
   parameter int PROG_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   localparam int CNT_W = $clog2(PROG_CYC + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= CNT_W'(PROG_CYC);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);

endmodule

// File: rtl/scr_store.sv
module scr_store
   import scr_pkg::*;
#(
   parameter int SIG_W            = 32,
   parameter int CFG_W            = 64,
   parameter bit PROG_CLEARS_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmd_kind_e        kind,
   input  logic [CFG_W-1:0] pdata,
   output logic [CFG_W-1:0] cfg,
   output logic [SIG_W-1:0] sig,
   output logic             secured
);

   logic [CFG_W-1:0] cfg_next;
   logic [SIG_W-1:0] sig_next;

   generate
      if (PROG_CLEARS_ONLY) begin : g_and_prog
         assign cfg_next = cfg & pdata;
         assign sig_next = sig & pdata[SIG_W-1:0];
      end else begin : g_direct_prog
         assign cfg_next = pdata;
         assign sig_next = pdata[SIG_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg     <= '1;
         sig     <= '1;
         secured <= 1'b0;
      end else begin
         case (kind)
            K_PCFG:  cfg     <= cfg_next;
            K_PSIG:  sig     <= sig_next;
            K_LOCK:  secured <= 1'b1;
            K_ERASE: begin
               cfg     <= '1;
               sig     <= '1;
               secured <= 1'b0;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
   parameter int CFG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] load_val,
   input  logic             shift_en,
   input  logic             sdi,
   output logic             sdo,
   output logic [CFG_W-1:0] din
);

   logic [CFG_W-1:0] dout;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
         din  <= '0;
      end else begin
         if (load) begin
            dout <= load_val;
         end else if (shift_en) begin
            dout <= {1'b0, dout[CFG_W-1:1]};
         end
         if (shift_en) begin
            din <= {sdi, din[CFG_W-1:1]};
         end
      end
   end

   assign sdo = dout[0];

endmodule

// File: rtl/scr_ctrl.sv
module scr_ctrl
   import scr_pkg::*;
#(
   parameter int               SIG_W            = 32,
   parameter int               CFG_W            = 64,
   parameter int               PROG_CYC         = 16,
   parameter logic [SIG_W-1:0] DEV_ID           = 32'h0C47_19E3,
   parameter bit               PROG_CLEARS_ONLY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_load,
   input  logic [7:0] op_code,
   input  logic       shift_en,
   input  logic       sdi,
   output logic       sdo,
   output logic       busy,
   output logic       blocked
);

   generate
      if (SIG_W < 1 || SIG_W > CFG_W) begin : g_bad_sig_w
         $error("scr_ctrl: SIG_W must lie in 1..CFG_W");
      end
      if (PROG_CYC < 1) begin : g_bad_prog_cyc
         $error("scr_ctrl: PROG_CYC must be at least 1");
      end
   endgenerate

   cmd_kind_e        kind;
   cmd_kind_e        kind_acc;
   logic             is_read;
   logic             is_prog;
   logic             accept;
   logic [CFG_W-1:0] cfg;
   logic [SIG_W-1:0] sig;
   logic             secured;
   logic [CFG_W-1:0] din;
   logic [CFG_W-1:0] rd_val;

   scr_decode u_dec (
      .op_code (op_code),
      .kind    (kind),
      .is_read (is_read),
      .is_prog (is_prog)
   );

   assign accept   = op_load && !busy && (kind != K_NONE);
   assign kind_acc = accept ? kind : K_NONE;

   scr_busy #(.PROG_CYC(PROG_CYC)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept && is_prog),
      .busy  (busy)
   );

   scr_store #(
      .SIG_W            (SIG_W),
      .CFG_W            (CFG_W),
      .PROG_CLEARS_ONLY (PROG_CLEARS_ONLY)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .kind    (kind_acc),
      .pdata   (din),
      .cfg     (cfg),
      .sig     (sig),
      .secured (secured)
   );

   always_comb begin
      case (kind_acc)
         K_RSIG:  rd_val = CFG_W'(sig);
         K_RID:   rd_val = CFG_W'(DEV_ID);
         K_RCFG:  rd_val = secured ? '0 : cfg;
         default: rd_val = '0;
      endcase
   end

   scr_shifter #(.CFG_W(CFG_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept && is_read),
      .load_val (rd_val),
      .shift_en (shift_en),
      .sdi      (sdi),
      .sdo      (sdo),
      .din      (din)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blocked <= 1'b0;
      end else if (accept) begin
         blocked <= (kind == K_RCFG) && secured;
      end
   end

endmodule

// File: rtl/scr_ctrl_chk.sv
module scr_ctrl_chk
   import scr_pkg::*;
#(
   parameter int PROG_CYC = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       op_load,
   input logic [7:0] op_code,
   input logic       busy,
   input logic       blocked,
   input logic       sdo,
   input logic       secured
);

   logic acc;
   logic prog_op;
   logic known;
   int   run;

   assign acc     = op_load && !busy;
   assign prog_op = (op_code == OP_PCFG) || (op_code == OP_PSIG) ||
                    (op_code == OP_LOCK) || (op_code == OP_ERASE);
   assign known   = prog_op || (op_code == OP_RSIG) ||
                    (op_code == OP_RID) || (op_code == OP_RCFG);

   always_ff @(posedge clk) begin
      if (!rst_n)    run <= 0;
      else if (busy) run <= run + 1;
      else           run <= 0;
   end

   a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && prog_op) |=> busy);

   a_r10_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run < PROG_CYC));

   a_r10_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run == PROG_CYC));

   a_r8_sec_only_erase: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(secured) |-> $past(acc && (op_code == OP_ERASE)));

   a_r9_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (op_code == OP_ERASE)) |=> !secured);

   a_r5_blocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> !sdo);

   a_r11_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !known) |=> (!busy && $stable(secured)));

endmodule

bind scr_ctrl scr_ctrl_chk #(.PROG_CYC(PROG_CYC)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_load (op_load),
   .op_code (op_code),
   .busy    (busy),
   .blocked (blocked),
   .sdo     (sdo),
   .secured (secured)
);

// File: tb/sim_scr_ctrl.sv
module sim_scr_ctrl;

   localparam int          SIG_W    = 32;
   localparam int          CFG_W    = 48;
   localparam int          PROG_CYC = 5;
   localparam logic [31:0] DEV_ID   = 32'h5A3C_9E61;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_load = 1'b0;
   logic [7:0] op_code = 8'h00;
   logic       shift_en = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo;
   logic       busy;
   logic       blocked;

   scr_ctrl #(
      .SIG_W    (SIG_W),
      .CFG_W    (CFG_W),
      .PROG_CYC (PROG_CYC),
      .DEV_ID   (DEV_ID)
   ) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_load  (op_load),
      .op_code  (op_code),
      .shift_en (shift_en),
      .sdi      (sdi),
      .sdo      (sdo),
      .busy     (busy),
      .blocked  (blocked)
   );

   always #4 clk = ~clk;

   int    n_chk = 0;
   int    n_bad = 0;
   string ctx = "R1";

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // reference model
   logic [CFG_W-1:0] m_cfg;
   logic [SIG_W-1:0] m_sig;
   bit               m_sec;
   bit               m_blk;
   int               m_cnt;
   bit               outq[$];
   bit               inq[$];

   always @(posedge clk) begin : mdl
      logic [CFG_W-1:0] pd;
      logic [CFG_W-1:0] rv;
      bit               acc;
      bit               isrd;
      bit               prog;
      if (!rst_n) begin
         m_cfg = '1;
         m_sig = '1;
         m_sec = 0;
         m_blk = 0;
         m_cnt = 0;
         outq.delete();
         inq.delete();
      end else begin
         pd = '0;
         rv = '0;
         for (int i = 0; i < inq.size(); i++) pd[CFG_W - inq.size() + i] = inq[i];
         acc  = op_load && (m_cnt == 0);
         isrd = 0;
         prog = 0;
         if (acc) begin
            case (op_code)
               8'h51: begin rv = CFG_W'(m_sig);  isrd = 1; m_blk = 0; end
               8'h52: begin rv = CFG_W'(DEV_ID); isrd = 1; m_blk = 0; end
               8'h53: begin rv = m_sec ? '0 : m_cfg; isrd = 1; m_blk = m_sec; end
               8'hA1: begin m_cfg = m_cfg & pd; prog = 1; m_blk = 0; end
               8'hA2: begin m_sig = m_sig & pd[SIG_W-1:0]; prog = 1; m_blk = 0; end
               8'hA5: begin m_sec = 1; prog = 1; m_blk = 0; end
               8'hE7: begin m_cfg = '1; m_sig = '1; m_sec = 0; prog = 1; m_blk = 0; end
               default: ;
            endcase
         end
         if (prog) m_cnt = PROG_CYC;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
         if (isrd) begin
            outq.delete();
            for (int i = 0; i < CFG_W; i++) outq.push_back(rv[i]);
         end else if (shift_en && outq.size() > 0) begin
            void'(outq.pop_front());
         end
         if (shift_en) begin
            inq.push_back(sdi);
            if (inq.size() > CFG_W) void'(inq.pop_front());
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin : cmp
         bit e_sdo;
         e_sdo = (outq.size() > 0) ? outq[0] : 1'b0;
         check((sdo === e_sdo) && (busy === (m_cnt != 0)) && (blocked === m_blk),
               {ctx, " model"}, {61'd0, sdo, busy, blocked},
               {61'd0, e_sdo, (m_cnt != 0), m_blk});
      end
   end

   // stimulus helpers, each entered at a falling edge
   task automatic cmd(input logic [7:0] op);
      op_code = op;
      op_load = 1'b1;
      @(negedge clk);
      op_load = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic shift_in(input logic [CFG_W-1:0] v);
      for (int i = 0; i < CFG_W; i++) begin
         sdi      = v[i];
         shift_en = 1'b1;
         @(negedge clk);
      end
      shift_en = 1'b0;
      sdi      = 1'b0;
   endtask

   task automatic read_bits(input logic [7:0] op, input int n, output logic [CFG_W-1:0] v);
      cmd(op);
      v = '0;
      for (int i = 0; i < n; i++) begin
         v[i]     = sdo;
         shift_en = 1'b1;
         @(negedge clk);
      end
      shift_en = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin : stim
      logic [CFG_W-1:0] v;
      logic [CFG_W-1:0] p1;
      logic [CFG_W-1:0] p2;
      int               c;
      p1 = 48'h0F0F_1234_ABCD;
      p2 = 48'hFFFF_FFFF_00FF;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      ctx = "R1";
      check(sdo === 1'b0 && busy === 1'b0 && blocked === 1'b0, "R1 outputs",
            {61'd0, sdo, busy, blocked}, 64'd0);
      read_bits(8'h53, CFG_W, v);
      check(v === {CFG_W{1'b1}}, "R1 blank image", 64'(v), 64'({CFG_W{1'b1}}));
      read_bits(8'h51, SIG_W, v);
      check(v[SIG_W-1:0] === '1, "R1 blank signature", 64'(v[SIG_W-1:0]), 64'hFFFF_FFFF);

      ctx = "R3";
      read_bits(8'h52, CFG_W, v);
      check(v === CFG_W'(DEV_ID), "R3 id unsecured", 64'(v), 64'(DEV_ID));

      ctx = "R6";
      shift_in(p1);
      cmd(8'hA1);
      ctx = "R10";
      c = 0;
      while (busy) begin c++; @(negedge clk); end
      check(c == PROG_CYC, "R10 busy length", 64'(c), 64'(PROG_CYC));
      ctx = "R4";
      read_bits(8'h53, CFG_W, v);
      check(v === p1, "R4 image readback", 64'(v), 64'(p1));
      ctx = "R6";
      shift_in(p2);
      cmd(8'hA1);
      wait_idle();
      read_bits(8'h53, CFG_W, v);
      check(v === (p1 & p2), "R6 program clears only", 64'(v), 64'(p1 & p2));

      ctx = "R7";
      shift_in(48'h0000_2024_0917);
      cmd(8'hA2);
      wait_idle();
      read_bits(8'h51, SIG_W, v);
      check(v[SIG_W-1:0] === 32'h2024_0917, "R7 signature program",
            64'(v[SIG_W-1:0]), 64'h2024_0917);

      ctx = "R10";
      shift_in(p2);
      cmd(8'hA1);
      cmd(8'h52);
      wait_idle();
      check(sdo === 1'b0, "R10 load during busy dropped", 64'(sdo), 64'd0);

      ctx = "R11";
      cmd(8'h00);
      cmd(8'hFF);
      check(busy === 1'b0 && blocked === 1'b0, "R11 unknown no busy",
            {62'd0, busy, blocked}, 64'd0);
      cmd(8'h51);
      v = '0;
      for (int i = 0; i < 4; i++) begin
         v[i] = sdo; shift_en = 1'b1; @(negedge clk);
      end
      shift_en = 1'b0;
      cmd(8'h3C);
      for (int i = 4; i < SIG_W; i++) begin
         v[i] = sdo; shift_en = 1'b1; @(negedge clk);
      end
      shift_en = 1'b0;
      check(v[SIG_W-1:0] === 32'h2024_0917, "R11 stream survives unknown",
            64'(v[SIG_W-1:0]), 64'h2024_0917);

      ctx = "R8";
      cmd(8'hA5);
      wait_idle();
      ctx = "R5";
      read_bits(8'h53, CFG_W, v);
      check(v === '0, "R5 refused read zeros", 64'(v), 64'd0);
      check(blocked === 1'b1, "R5 blocked set", 64'(blocked), 64'd1);
      ctx = "R2";
      read_bits(8'h51, SIG_W, v);
      check(v[SIG_W-1:0] === 32'h2024_0917, "R2 signature while secured",
            64'(v[SIG_W-1:0]), 64'h2024_0917);
      check(blocked === 1'b0, "R5 blocked cleared", 64'(blocked), 64'd0);
      ctx = "R3";
      read_bits(8'h52, CFG_W, v);
      check(v === CFG_W'(DEV_ID), "R3 id while secured", 64'(v), 64'(DEV_ID));
      ctx = "R8";
      shift_in('0);
      cmd(8'hA1);
      wait_idle();
      cmd(8'hA2);
      wait_idle();
      read_bits(8'h53, CFG_W, v);
      check(v === '0 && blocked === 1'b1, "R8 lock survives programming",
            64'(blocked), 64'd1);

      ctx = "R9";
      cmd(8'hE7);
      wait_idle();
      read_bits(8'h53, CFG_W, v);
      check(v === {CFG_W{1'b1}}, "R9 image erased", 64'(v), 64'({CFG_W{1'b1}}));
      check(blocked === 1'b0, "R9 unlocked", 64'(blocked), 64'd0);
      read_bits(8'h51, SIG_W, v);
      check(v[SIG_W-1:0] === '1, "R9 signature erased", 64'(v[SIG_W-1:0]), 64'hFFFF_FFFF);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule